// File: doc/BRIEF.md
# Longest Prefix Match Lookup Engine

This block resolves a 32-bit IPv4 destination address to an outgoing port number. It holds a small, fully parallel table of route entries. Each entry carries a prefix value, a prefix length between 0 and 32, a port number and a valid flag. A lookup compares the address against every valid entry at once. Only the top `length` bits of an entry take part in the comparison. Among the entries that match, the one with the longest prefix decides the result, so the most specific route wins over the broader ones that overlap it.

A single configuration write port loads or removes entries one slot per cycle. Lookups enter with a valid strobe and leave exactly two cycles later with a valid strobe, a hit flag and the chosen port. A new lookup can be accepted on every clock and there is no backpressure. One result per clock meets a 33 ns per-lookup budget at any clock of 31.25 MHz or faster.

Top module: `lpm_lookup`

## Requirements
- R1: After reset, `out_valid` and `out_hit` are low and every table slot is invalid, so a lookup made before any write returns a miss.
- R2: A lookup sampled with `lk_valid` high at clock edge k produces `out_valid` high after edge k+2. Lookups on consecutive cycles give results on consecutive cycles, in the order they were issued.
- R3: An entry of length L matches an address when the top L bits of the address equal the top L bits of the entry's prefix. The low 32-L bits of both the address and the prefix are ignored.
- R4: When several valid entries match, the result port is the port of the matching entry with the greatest length.
- R5: A valid entry of length 0 matches every address and acts as a default route.
- R6: When no valid entry matches, `out_hit` is 0 and `out_port` is 0.
- R7: When matching entries share the greatest length, the entry in the lowest slot index wins.
- R8: A table write sampled at edge k affects lookups sampled at edge k+1 and later. A lookup sampled at the same edge as the write still sees the old contents.
- R9: Writing a slot with `cfg_valid` = 0 removes that entry from all later lookups.
- R10: A length written above 32 is stored and applied as 32, which is an exact host match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_idx | input | IDX_W | Slot being written |
| cfg_prefix | input | 32 | Prefix value to store |
| cfg_len | input | 6 | Prefix length, 0 to 32 (larger values are clamped to 32) |
| cfg_port | input | PORT_W | Port returned when this entry wins |
| cfg_valid | input | 1 | 1 installs the entry, 0 removes it |
| lk_valid | input | 1 | Lookup request strobe |
| lk_addr | input | 32 | Destination address to look up |
| out_valid | output | 1 | Result strobe, two cycles after the request |
| out_hit | output | 1 | At least one valid entry matched |
| out_port | output | PORT_W | Port of the winning entry, 0 on a miss |

## Verification
The bench loads overlapping /8, /16, /19, /21 and /24 routes and sweeps over a thousand addresses on both sides of each prefix boundary. A design that compares too many or too few bits would misroute addresses at the first or last address of a range. A design that picks the first match instead of the longest would send 128.9.16.14 to the /16 port. The sweep is repeated after a default route is added and after an entry is removed. This catches a length-0 entry that matches nothing and a cleared entry that still wins. Further cases cover duplicate prefixes, where a wrong tie-break returns the higher slot's port, and a length above 32, which would wrap if not clamped. A write and a lookup are also issued on the same cycle: a design that forwards the new value into that lookup, or that reads live table state in the second stage, returns the wrong port.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  localparam int ADDR_W  = 32;
  localparam int LEN_W   = 6;
  localparam int MAX_LEN = 32;

  // Mask with the top `l` bits set; lengths beyond 32 saturate.
  function automatic logic [ADDR_W-1:0] len_mask(input logic [LEN_W-1:0] l);
    logic [ADDR_W-1:0] m;
    for (int b = 0; b < ADDR_W; b++) begin
      m[ADDR_W-1-b] = (b < int'(l));
    end
    return m;
  endfunction

endpackage

// File: rtl/lpm_table.sv
module lpm_table
  import lpm_pkg::*;
#(
  parameter int N_ENTRIES = 8,
  parameter int PORT_W    = 4,
  localparam int IDX_W    = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 cfg_we,
  input  logic [IDX_W-1:0]                     cfg_idx,
  input  logic [ADDR_W-1:0]                    cfg_prefix,
  input  logic [LEN_W-1:0]                     cfg_len,
  input  logic [PORT_W-1:0]                    cfg_port,
  input  logic                                 cfg_valid,
  output logic [N_ENTRIES-1:0]                 tbl_vld,
  output logic [N_ENTRIES-1:0][ADDR_W-1:0]     tbl_prefix,
  output logic [N_ENTRIES-1:0][LEN_W-1:0]      tbl_len,
  output logic [N_ENTRIES-1:0][PORT_W-1:0]     tbl_port
);

  logic [LEN_W-1:0] len_clamped;

  always_comb begin
    len_clamped = (cfg_len > LEN_W'(MAX_LEN)) ? LEN_W'(MAX_LEN) : cfg_len;
  end

  // Slots are flops: every slot is read on every cycle by the comparators.
  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        tbl_vld[g]    <= 1'b0;
        tbl_prefix[g] <= '0;
        tbl_len[g]    <= '0;
        tbl_port[g]   <= '0;
      end else if (cfg_we && (int'(cfg_idx) == g)) begin
        tbl_vld[g]    <= cfg_valid;
        tbl_prefix[g] <= cfg_prefix;
        tbl_len[g]    <= len_clamped;
        tbl_port[g]   <= cfg_port;
      end
    end
  end

  // R10: the stored length never exceeds 32
  a_r10_len_clamped: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> (tbl_len[$past(cfg_idx)] <= LEN_W'(MAX_LEN)));

  // R9: a removal write leaves the slot invalid
  a_r9_remove: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && !cfg_valid) |=> !tbl_vld[$past(cfg_idx)]);

endmodule

// File: rtl/lpm_match.sv
module lpm_match
  import lpm_pkg::*;
#(
  parameter int N_ENTRIES = 8
) (
  input  logic [ADDR_W-1:0]                 addr,
  input  logic [N_ENTRIES-1:0]              tbl_vld,
  input  logic [N_ENTRIES-1:0][ADDR_W-1:0]  tbl_prefix,
  input  logic [N_ENTRIES-1:0][LEN_W-1:0]   tbl_len,
  output logic [N_ENTRIES-1:0]              match
);

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_cmp
    logic [ADDR_W-1:0] mask;
    always_comb begin
      mask     = len_mask(tbl_len[g]);
      match[g] = tbl_vld[g] && (((addr ^ tbl_prefix[g]) & mask) == '0);
    end
  end

endmodule

// File: rtl/lpm_select.sv
module lpm_select
  import lpm_pkg::*;
#(
  parameter int N_ENTRIES = 8,
  parameter int PORT_W    = 4,
  localparam int IDX_W    = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic [N_ENTRIES-1:0]              match,
  input  logic [N_ENTRIES-1:0][LEN_W-1:0]   lens,
  input  logic [N_ENTRIES-1:0][PORT_W-1:0]  ports,
  output logic                              found,
  output logic [IDX_W-1:0]                  win_idx,
  output logic [PORT_W-1:0]                 win_port
);

  logic [LEN_W-1:0] best_len;

  // Strict greater-than keeps the lowest index on equal lengths.
  always_comb begin
    found    = 1'b0;
    win_idx  = '0;
    best_len = '0;
    for (int i = 0; i < N_ENTRIES; i++) begin
      if (match[i] && (!found || (lens[i] > best_len))) begin
        found    = 1'b1;
        win_idx  = IDX_W'(i);
        best_len = lens[i];
      end
    end
    win_port = ports[win_idx];
  end

endmodule

// File: rtl/lpm_lookup.sv
module lpm_lookup
  import lpm_pkg::*;
#(
  parameter int N_ENTRIES = 8,
  parameter int PORT_W    = 4,
  localparam int IDX_W    = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [31:0]       cfg_prefix,
  input  logic [5:0]        cfg_len,
  input  logic [PORT_W-1:0] cfg_port,
  input  logic              cfg_valid,
  input  logic              lk_valid,
  input  logic [31:0]       lk_addr,
  output logic              out_valid,
  output logic              out_hit,
  output logic [PORT_W-1:0] out_port
);

  logic [N_ENTRIES-1:0]              tbl_vld;
  logic [N_ENTRIES-1:0][ADDR_W-1:0]  tbl_prefix;
  logic [N_ENTRIES-1:0][LEN_W-1:0]   tbl_len;
  logic [N_ENTRIES-1:0][PORT_W-1:0]  tbl_port;
  logic [N_ENTRIES-1:0]              match_c;

  // Stage 1 registers: match vector plus a snapshot of lengths and ports
  logic                              s1_vld;
  logic [N_ENTRIES-1:0]              s1_match;
  logic [N_ENTRIES-1:0][LEN_W-1:0]   s1_len;
  logic [N_ENTRIES-1:0][PORT_W-1:0]  s1_port;

  logic              sel_found;
  logic [IDX_W-1:0]  sel_idx;
  logic [PORT_W-1:0] sel_port;
  logic              has_default;

  lpm_table #(.N_ENTRIES(N_ENTRIES), .PORT_W(PORT_W)) u_table (
    .clk        (clk),
    .rst        (rst),
    .cfg_we     (cfg_we),
    .cfg_idx    (cfg_idx),
    .cfg_prefix (cfg_prefix),
    .cfg_len    (cfg_len),
    .cfg_port   (cfg_port),
    .cfg_valid  (cfg_valid),
    .tbl_vld    (tbl_vld),
    .tbl_prefix (tbl_prefix),
    .tbl_len    (tbl_len),
    .tbl_port   (tbl_port)
  );

  lpm_match #(.N_ENTRIES(N_ENTRIES)) u_match (
    .addr       (lk_addr),
    .tbl_vld    (tbl_vld),
    .tbl_prefix (tbl_prefix),
    .tbl_len    (tbl_len),
    .match      (match_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld   <= 1'b0;
      s1_match <= '0;
      s1_len   <= '0;
      s1_port  <= '0;
    end else begin
      s1_vld   <= lk_valid;
      s1_match <= lk_valid ? match_c : '0;
      s1_len   <= tbl_len;
      s1_port  <= tbl_port;
    end
  end

  lpm_select #(.N_ENTRIES(N_ENTRIES), .PORT_W(PORT_W)) u_select (
    .match    (s1_match),
    .lens     (s1_len),
    .ports    (s1_port),
    .found    (sel_found),
    .win_idx  (sel_idx),
    .win_port (sel_port)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_hit   <= 1'b0;
      out_port  <= '0;
    end else begin
      out_valid <= s1_vld;
      out_hit   <= s1_vld && sel_found;
      out_port  <= (s1_vld && sel_found) ? sel_port : '0;
    end
  end

  always_comb begin
    has_default = 1'b0;
    for (int i = 0; i < N_ENTRIES; i++) begin
      if (tbl_vld[i] && (tbl_len[i] == '0)) has_default = 1'b1;
    end
  end

  // R2: every request returns a result two edges later
  a_r2_fixed_latency: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> ##1 out_valid);

  // R2: no hit is reported without a result strobe
  a_r2_hit_needs_valid: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> !out_hit);

  // R6: a miss drives port zero
  a_r6_miss_port_zero: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_hit) |-> (out_port == '0));

  // R5: a live default route guarantees a hit
  a_r5_default_hits: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && has_default) |=> ##1 out_hit);

  // R4: the chosen slot is one that matched
  a_r4_winner_matched: assert property (@(posedge clk) disable iff (rst)
    sel_found |-> s1_match[sel_idx]);

endmodule

// File: tb/lpm_lookup_tb.sv
module lpm_lookup_tb;

  localparam int N  = 8;
  localparam int PW = 4;
  localparam int IW = 3;
  localparam int QD = 4096;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic [IW-1:0] cfg_idx = '0;
  logic [31:0]   cfg_prefix = '0;
  logic [5:0]    cfg_len = '0;
  logic [PW-1:0] cfg_port = '0;
  logic          cfg_valid = 1'b0;
  logic          lk_valid = 1'b0;
  logic [31:0]   lk_addr = '0;
  logic          out_valid;
  logic          out_hit;
  logic [PW-1:0] out_port;

  always #10 clk = ~clk;

  lpm_lookup #(.N_ENTRIES(N), .PORT_W(PW)) u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_prefix(cfg_prefix), .cfg_len(cfg_len), .cfg_port(cfg_port),
    .cfg_valid(cfg_valid), .lk_valid(lk_valid), .lk_addr(lk_addr),
    .out_valid(out_valid), .out_hit(out_hit), .out_port(out_port)
  );

  // Bench reference table
  bit          m_v   [N];
  logic [31:0] m_pfx [N];
  int          m_len [N];
  int          m_port[N];

  // Expected-result queue
  int    q_cyc [QD];
  bit    q_hit [QD];
  int    q_port[QD];
  string q_tag [QD];
  int    wr_p = 0, rd_p = 0;
  int    cyc = 0;
  int    checks = 0, errors = 0;
  bit    done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic model(input logic [31:0] a, output bit hit, output int port);
    int best = -1;
    for (int i = 0; i < N; i++) begin
      logic [31:0] mk;
      mk = (m_len[i] == 0) ? 32'h0 : (32'hFFFF_FFFF << (32 - m_len[i]));
      if (m_v[i] && (((a ^ m_pfx[i]) & mk) == 32'h0)) begin
        if (best < 0 || m_len[i] > m_len[best]) best = i;
      end
    end
    hit  = (best >= 0);
    port = hit ? m_port[best] : 0;
  endtask

  task automatic drive_lookup(input logic [31:0] a, input string tag);
    bit h; int p;
    model(a, h, p);
    lk_valid = 1'b1;
    lk_addr  = a;
    q_cyc[wr_p]  = cyc;
    q_hit[wr_p]  = h;
    q_port[wr_p] = p;
    q_tag[wr_p]  = tag;
    wr_p++;
  endtask

  task automatic drive_write(input int idx, input logic [31:0] pfx, input int len,
                             input int port, input bit v);
    cfg_we = 1'b1; cfg_idx = IW'(idx); cfg_prefix = pfx;
    cfg_len = 6'(len); cfg_port = PW'(port); cfg_valid = v;
    m_v[idx] = v; m_pfx[idx] = pfx; m_len[idx] = (len > 32) ? 32 : len;
    m_port[idx] = port;
  endtask

  task automatic step();
    @(negedge clk);
    lk_valid = 1'b0;
    cfg_we   = 1'b0;
  endtask

  task automatic write_entry(input int idx, input logic [31:0] pfx, input int len,
                             input int port, input bit v);
    drive_write(idx, pfx, len, port, v);
    step();
  endtask

  task automatic look(input logic [31:0] a, input string tag);
    drive_lookup(a, tag);
    step();
  endtask

  task automatic sweep(input string tag);
    for (int i = 0; i < 1024; i++) begin
      logic [31:0] a;
      a = (32'(i) * 32'h0041_A7C3) ^ (32'(i) << 22);
      if (i % 4 == 1) a = {8'd128, 8'd9, 16'(i * 97)};
      if (i % 4 == 2) a = {8'd65, 24'(i * 40503)};
      if (i % 8 == 3) a = {8'd142, 8'd12, 16'(i * 31)};
      drive_lookup(a, tag);
      step();
    end
  endtask

  // Monitor: compares every result cycle against the queue
  always @(negedge clk) begin
    if (!rst && !done) begin
      bit exp_v;
      exp_v = (rd_p < wr_p) && (q_cyc[rd_p] + 2 == cyc);
      if (out_valid !== exp_v) begin
        checks++; errors++;
        $display("FAIL R2 out_valid actual=%0b expected=%0b at cycle %0d", out_valid, exp_v, cyc);
      end
      if (exp_v) begin
        checks++;
        if (out_hit !== q_hit[rd_p] || int'(out_port) != q_port[rd_p]) begin
          errors++;
          $display("FAIL %s hit/port actual=%0b/%0d expected=%0b/%0d", q_tag[rd_p],
                   out_hit, out_port, q_hit[rd_p], q_port[rd_p]);
        end
        rd_p++;
      end
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      m_v[i] = 0; m_pfx[i] = '0; m_len[i] = 0; m_port[i] = 0;
    end
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_hit !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset outputs actual=%0b/%0b expected=0/0", out_valid, out_hit);
    end
    rst = 1'b0;
    // R1: empty table misses
    look(32'h4101_0203, "R1");
    look(32'h0000_0000, "R1");

    // Reference routes
    write_entry(0, {8'd65, 24'd0}, 8, 3, 1);
    write_entry(1, {8'd128, 8'd9, 16'd0}, 16, 1, 1);
    write_entry(2, {8'd142, 8'd12, 16'd0}, 19, 7, 1);
    write_entry(3, {8'd128, 8'd9, 8'd16, 8'd0}, 21, 2, 1);
    write_entry(4, {8'd128, 8'd9, 8'd172, 8'd0}, 21, 4, 1);
    write_entry(5, {8'd128, 8'd9, 8'd176, 8'd0}, 24, 5, 1);

    // R4: most specific route wins
    look({8'd128, 8'd9, 8'd16, 8'd14}, "R4");
    look({8'd128, 8'd9, 8'd200, 8'd1}, "R4");
    look({8'd128, 8'd9, 8'd176, 8'd9}, "R4");
    look({8'd128, 8'd9, 8'd23, 8'd255}, "R4");
    // R3: range edges
    look({8'd65, 24'd0}, "R3");
    look({8'd65, 24'hFF_FFFF}, "R3");
    look({8'd142, 8'd12, 8'd31, 8'd255}, "R3");
    // R6: just outside the ranges
    look({8'd64, 24'hFF_FFFF}, "R6");
    look({8'd66, 24'd0}, "R6");
    look({8'd142, 8'd12, 8'd32, 8'd0}, "R6");
    // R2: back-to-back stream
    sweep("R4");

    // R5: default route
    write_entry(6, 32'hDEAD_BEEF, 0, 9, 1);
    look(32'h0102_0304, "R5");
    look(32'hFFFF_FFFF, "R5");
    sweep("R5");

    // R7: duplicate of slot 0 in slot 7 loses
    write_entry(7, {8'd65, 24'h12_3456}, 8, 12, 1);
    look({8'd65, 24'h00_0001}, "R7");

    // R10: length 40 acts as /32
    write_entry(7, {8'd142, 8'd12, 8'd0, 8'd9}, 40, 12, 1);
    look({8'd142, 8'd12, 8'd0, 8'd9}, "R10");
    look({8'd142, 8'd12, 8'd0, 8'd8}, "R10");

    // R8: same-cycle write is not seen; next-cycle lookup is
    drive_lookup({8'd128, 8'd9, 8'd16, 8'd14}, "R8");
    drive_write(3, {8'd128, 8'd9, 8'd16, 8'd0}, 21, 11, 1);
    step();
    look({8'd128, 8'd9, 8'd16, 8'd14}, "R8");
    // same-cycle write lands between stages of the previous lookup
    drive_lookup({8'd128, 8'd9, 8'd16, 8'd15}, "R8");
    step();
    write_entry(3, {8'd128, 8'd9, 8'd16, 8'd0}, 21, 13, 1);

    // R9: remove the /21 and the default
    write_entry(3, 32'h0, 0, 0, 0);
    look({8'd128, 8'd9, 8'd16, 8'd14}, "R9");
    write_entry(6, 32'h0, 0, 0, 0);
    look(32'h0102_0304, "R9");
    sweep("R9");

    repeat (4) step();
    done = 1'b1;
    checks++;
    if (rd_p != wr_p) begin
      errors++;
      $display("FAIL R2 results actual=%0d expected=%0d", rd_p, wr_p);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 100000);
    done = 1'b1;
    checks++; errors++;
    $display("FAIL R2 watchdog actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule